// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA Channel

This block carries a byte stream from a peripheral into system memory. Bytes enter on a valid/ready port and collect in a 64-entry buffer. A single channel then writes them to memory, one byte per cycle, as a linked list of descriptors directs. The channel reads each descriptor over a word-wide read port that holds its request until the memory answers. It writes bytes over a byte-wide write port that cannot stall.

Software writes a head pointer and issues a start command. The channel then walks the list on its own. After the descriptor marked as the last one, it clears the head pointer, raises a status bit and gives a one-cycle completion pulse. It takes nothing more from the buffer until software starts it again. Any bytes that arrive in the meantime wait in the buffer, and when it is full the peripheral is held off. A separate flush command throws away everything that is buffered.

Top module: `pdma_rx`

## Requirements
- R1: The buffer holds exactly 64 bytes. With the channel not draining it, 64 handshakes complete from empty, and then `in_ready` goes low.
- R2: A burst of removal starts only when the buffer holds at least 32 bytes. While fewer are held and no burst is running, no memory write occurs.
- R3: When the buffer is full, `in_ready` is low and no byte is accepted until an entry is removed.
- R4: For each descriptor the channel writes exactly as many bytes as its length field gives. They go to consecutive addresses starting at its buffer address, in arrival order.
- R5: Once the channel removes entries from a full buffer, `in_ready` returns high.
- R6: When a descriptor with the end-of-list flag completes, `first_ptr` reads 0, `list_done` is 1 and `done_pulse` is high for exactly one cycle.
- R7: After the list ends, no byte leaves the buffer until a restart. The bytes held are written in order after the next restart.
- R8: `sw_flush` empties the buffer. Afterwards up to 64 new bytes are accepted, and the first byte written to memory is the first byte accepted after the flush.
- R9: A descriptor is four 32-bit words at pointer +0, +4, +8 and +12: length (low 16 bits), buffer address, next pointer, and flags with end-of-list in bit 0. If the flag is clear, the channel goes on to the next pointer by itself, and `first_ptr` shows that pointer.
- R10: While `busy` is high, a restart and a head-pointer write have no effect. A restart clears `list_done`. A restart with a zero head pointer leaves the channel idle.
- R11: After reset, `first_ptr` is 0, `in_ready` is 1, and `busy`, `list_done`, `rd_req` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Peripheral byte valid |
| in_data | input | 8 | Peripheral byte |
| in_ready | output | 1 | Buffer can accept a byte |
| sw_first_wr | input | 1 | Write head pointer (taken only when idle) |
| sw_first_data | input | ADDR_W | Head pointer value |
| sw_restart | input | 1 | Start the channel from the head pointer |
| sw_flush | input | 1 | Empty the buffer |
| first_ptr | output | ADDR_W | Current head descriptor pointer |
| busy | output | 1 | Channel is walking a list |
| list_done | output | 1 | End-of-list reached since last restart |
| done_pulse | output | 1 | One-cycle end-of-list completion pulse |
| rd_req | output | 1 | Descriptor word read request, held until rd_valid |
| rd_addr | output | ADDR_W | Descriptor word address |
| rd_valid | input | 1 | Read data valid; completes the request |
| rd_data | input | 32 | Descriptor word |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | ADDR_W | Memory byte address |
| wr_data | output | 8 | Memory byte data |

## Verification
The hardest state to reach is a channel that has finished its list while the buffer sits completely full. Reaching it from the ports takes four steps. First, 20 bytes are pushed, which is below the half-full threshold, and the bench confirms that nothing is written. Then 12 more are pushed so that a 13-byte last descriptor drains. After that the bench keeps pushing until it is refused, and it counts exactly 45 accepted bytes. Finally a chained restart must drain those held bytes in order. A busy-time restart is brought about by stalling the second descriptor of a chain below the threshold, so the channel is certain to be busy when the command arrives.

// File: rtl/pdma_pkg.sv
// Shared types for the receive DMA channel.
// Assumes descriptor words are 32 bits and four words per descriptor.
package pdma_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_FETCH = 2'd1,
        CH_XFER  = 2'd2
    } ch_state_e;
endpackage

// File: rtl/pdma_fifo.sv
// Byte buffer between the peripheral and the channel.
// Raises svc_req at half-full; ready only when not full; flush empties it.
// Assumes DEPTH is a power of two so pointers wrap naturally.
module pdma_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          svc_req
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          do_push, do_pop;

    assign push_ready = (count_q != CW'(DEPTH));
    assign empty      = (count_q == '0);
    assign svc_req    = (count_q >= CW'(HALF));
    assign head       = mem_q[rd_ptr_q];
    assign do_push    = push_valid && push_ready && !flush;
    assign do_pop     = pop && !empty && !flush;

    // Storage write for accepted bytes.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= push_data;
    end

    // Pointer and occupancy bookkeeping, flush clears all.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH)); // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CW'(DEPTH)) && !pop && !flush |=> count_q == CW'(DEPTH)); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R8
endmodule

// File: rtl/pdma_chan.sv
// Descriptor-walking channel: fetches four-word descriptors, then removes
// exactly the described byte count from the buffer and writes it to memory.
// Assumes the read port holds rd_req until rd_valid and writes never stall.
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_wr,
    input  logic [ADDR_W-1:0] first_din,
    input  logic              restart,
    output logic [ADDR_W-1:0] first_ptr,
    output logic              busy,
    output logic              status,
    output logic              done_pulse,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              fifo_empty,
    input  logic              fifo_svc,
    output logic              fifo_pop,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int IDX_W = $clog2(DESC_WORDS);

    ch_state_e         st_q;
    logic [LEN_W-1:0]  remain_q;
    logic [ADDR_W-1:0] buf_q, next_q, cur_q, first_q;
    logic [IDX_W-1:0]  widx_q;
    logic              eol_q, burst_q, status_q, done_q;
    logic              pop;

    // Remove a byte while the descriptor has room and a burst is running or requested.
    assign pop = (st_q == CH_XFER) && (remain_q != '0) && !fifo_empty
                 && (burst_q || fifo_svc);

    assign fifo_pop   = pop;
    assign wr_en      = pop;
    assign wr_addr    = buf_q;
    assign rd_req     = (st_q == CH_FETCH);
    assign rd_addr    = cur_q + ADDR_W'({widx_q, 2'b00});
    assign first_ptr  = first_q;
    assign busy       = (st_q != CH_IDLE);
    assign status     = status_q;
    assign done_pulse = done_q;

    // Channel sequencer: idle/start, descriptor fetch, transfer and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CH_IDLE;
            remain_q <= '0;
            buf_q    <= '0;
            next_q   <= '0;
            cur_q    <= '0;
            first_q  <= '0;
            widx_q   <= '0;
            eol_q    <= 1'b0;
            burst_q  <= 1'b0;
            status_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            burst_q <= pop && (remain_q != LEN_W'(1));
            case (st_q)
                CH_IDLE: begin
                    if (first_wr) first_q <= first_din;
                    if (restart) begin
                        status_q <= 1'b0;
                        if (first_q != '0) begin
                            st_q   <= CH_FETCH;
                            cur_q  <= first_q;
                            widx_q <= '0;
                        end
                    end
                end
                CH_FETCH: begin
                    if (rd_valid) begin
                        widx_q <= widx_q + 1'b1;
                        case (widx_q)
                            IDX_W'(0): remain_q <= rd_data[LEN_W-1:0];
                            IDX_W'(1): buf_q    <= rd_data[ADDR_W-1:0];
                            IDX_W'(2): next_q   <= rd_data[ADDR_W-1:0];
                            default: begin
                                eol_q <= rd_data[0];
                                st_q  <= CH_XFER;
                            end
                        endcase
                    end
                end
                CH_XFER: begin
                    if (pop) begin
                        remain_q <= remain_q - 1'b1;
                        buf_q    <= buf_q + 1'b1;
                    end else if (remain_q == '0) begin
                        if (eol_q) begin
                            first_q  <= '0;
                            status_q <= 1'b1;
                            done_q   <= 1'b1;
                            st_q     <= CH_IDLE;
                        end else begin
                            first_q <= next_q;
                            cur_q   <= next_q;
                            widx_q  <= '0;
                            st_q    <= CH_FETCH;
                        end
                    end
                end
                default: st_q <= CH_IDLE;
            endcase
        end
    end

    AST_BURST_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !burst_q |-> fifo_svc); // R2
    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pop) && ($past(remain_q) == LEN_W'(1)) |-> !pop); // R4
    AST_EOL_CLEARS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (first_q == '0) && status_q); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6
    AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pop); // R7
    AST_BUSY_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_XFER) && (remain_q != '0) && restart |=> st_q == CH_XFER); // R10
endmodule

// File: rtl/pdma_rx.sv
// Top of the receive DMA: peripheral byte stream into a half-full-triggered
// buffer, drained by a single descriptor-chained channel into memory.
// Assumes one clock domain; memory write port always accepts.
module pdma_rx
    import pdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    input  logic              sw_first_wr,
    input  logic [ADDR_W-1:0] sw_first_data,
    input  logic              sw_restart,
    input  logic              sw_flush,
    output logic [ADDR_W-1:0] first_ptr,
    output logic              busy,
    output logic              list_done,
    output logic              done_pulse,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    logic f_empty, f_svc, f_pop;

    pdma_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(sw_flush),
        .push_valid(in_valid), .push_data(in_data), .push_ready(in_ready),
        .pop(f_pop), .head(wr_data), .empty(f_empty), .svc_req(f_svc)
    );

    pdma_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .first_wr(sw_first_wr), .first_din(sw_first_data), .restart(sw_restart),
        .first_ptr(first_ptr), .busy(busy), .status(list_done), .done_pulse(done_pulse),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .fifo_empty(f_empty), .fifo_svc(f_svc), .fifo_pop(f_pop),
        .wr_en(wr_en), .wr_addr(wr_addr)
    );

    AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !f_empty); // R4
endmodule

// File: tb/pdma_rx_tb_top.sv
module pdma_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        sw_first_wr = 1'b0;
    logic [31:0] sw_first_data = '0;
    logic        sw_restart = 1'b0;
    logic        sw_flush = 1'b0;
    logic [31:0] first_ptr;
    logic        busy, list_done, done_pulse, rd_req, wr_en;
    logic [31:0] rd_addr, wr_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic [7:0]  wr_data;

    pdma_rx dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .sw_first_wr(sw_first_wr), .sw_first_data(sw_first_data), .sw_restart(sw_restart),
        .sw_flush(sw_flush), .first_ptr(first_ptr), .busy(busy), .list_done(list_done),
        .done_pulse(done_pulse), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, seq = 0, wr_cnt = 0, done_cnt = 0, cyc = 0;
    logic [31:0] dmem [64];
    logic [31:0] exp_addr_q [$];
    logic [7:0]  exp_data_q [$];

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model answers descriptor reads in the same cycle.
    always @(negedge clk) begin
        rd_valid = rd_req;
        rd_data  = dmem[rd_addr[7:2]];
    end

    // Monitor: pops the scoreboard on each memory write.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            wr_cnt++;
            if (exp_addr_q.size() == 0) begin
                chk(1'b0, "R4 unexpected write", longint'(wr_addr), 0);
            end else begin
                logic [31:0] ea;
                logic [7:0]  ed;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                chk(wr_addr == ea, "R4 write address", longint'(wr_addr), longint'(ea));
                chk(wr_data == ed, "R4/R7 write data", longint'(wr_data), longint'(ed));
            end
        end
        if (rst_n && done_pulse) done_cnt++;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver: expected bytes for one descriptor go into the scoreboard.
    task automatic expect_desc(input logic [31:0] base, input int len, input int first_seq);
        for (int i = 0; i < len; i++) begin
            exp_addr_q.push_back(base + 32'(i));
            exp_data_q.push_back(8'(first_seq + i));
        end
    endtask

    task automatic put_desc(input int idx, input logic [31:0] len, input logic [31:0] bptr,
                            input logic [31:0] nptr, input logic [31:0] flags);
        dmem[idx] = len; dmem[idx+1] = bptr; dmem[idx+2] = nptr; dmem[idx+3] = flags;
    endtask

    task automatic push_bytes(input int n, input int tries, output int acc);
        acc = 0;
        for (int i = 0; i < tries && acc < n; i++) begin
            @(negedge clk);
            if (in_ready) begin
                in_valid = 1'b1; in_data = 8'(seq); seq++; acc++;
            end else in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic sw_first(input logic [31:0] v);
        @(negedge clk); sw_first_wr = 1'b1; sw_first_data = v;
        @(negedge clk); sw_first_wr = 1'b0;
    endtask

    task automatic sw_go();
        @(negedge clk); sw_restart = 1'b1;
        @(negedge clk); sw_restart = 1'b0;
    endtask

    task automatic wait_done(input int target, input string tag);
        int t = 0;
        while (done_cnt < target && t < 3000) begin @(negedge clk); t++; end
        chk(done_cnt == target, tag, done_cnt, target);
    endtask

    initial begin
        int acc;
        int t;
        int post_seq;
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(first_ptr == 0, "R11 first_ptr", first_ptr, 0);
        chk(in_ready == 1'b1, "R11 in_ready", in_ready, 1);
        chk({busy, list_done, rd_req, wr_en} == 4'b0, "R11 idle outputs",
            {busy, list_done, rd_req, wr_en}, 0);

        // R10 restart with zero head stays idle
        sw_go();
        repeat (3) @(negedge clk);
        chk(!busy && !rd_req, "R10 zero head restart", busy, 0);

        // R9 layout: len, buf, next, flags(bit0 eol); single last descriptor of 13
        put_desc(4, 13, 32'h1000, 0, 1);
        sw_first(32'h10);
        sw_go();
        push_bytes(20, 40, acc);
        repeat (10) @(negedge clk);
        chk(wr_cnt == 0, "R2 no drain below half", wr_cnt, 0);
        chk(busy, "R2 channel waiting", busy, 1);
        expect_desc(32'h1000, 13, 0);
        push_bytes(12, 40, acc);
        wait_done(1, "R6 done count");
        chk(first_ptr == 0, "R6 head cleared", first_ptr, 0);
        chk(list_done, "R6 status set", list_done, 1);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R6 single pulse", done_cnt, 1);

        // R3/R1/R7: list ended, 19 bytes held, fill to full
        push_bytes(60, 80, acc);
        chk(acc == 45, "R1/R3 accepted until full", acc, 45);
        chk(!in_ready, "R3 full stalls input", in_ready, 0);
        repeat (20) @(negedge clk);
        chk(wr_cnt == 13, "R7 no drain after list end", wr_cnt, 13);

        // R9 chain: 40 bytes then 10 bytes
        put_desc(16, 40, 32'h2000, 32'h80, 0);
        put_desc(32, 10, 32'h3000, 0, 1);
        expect_desc(32'h2000, 40, 13);
        expect_desc(32'h3000, 10, 53);
        sw_first(32'h40);
        sw_go();
        chk(!list_done, "R10 restart clears status", list_done, 0);
        t = 0;
        while (wr_cnt < 53 && t < 3000) begin @(negedge clk); t++; end
        repeat (8) @(negedge clk);
        chk(wr_cnt == 53, "R4 first chained length", wr_cnt, 53);
        chk(first_ptr == 32'h80, "R9 head follows next pointer", first_ptr, 32'h80);
        chk(in_ready, "R5 space freed", in_ready, 1);
        chk(busy, "R9 channel continues", busy, 1);

        // R10 busy: head write and restart ignored
        sw_first(32'h10);
        sw_go();
        repeat (3) @(negedge clk);
        chk(first_ptr == 32'h80, "R10 busy head write ignored", first_ptr, 32'h80);
        chk(wr_cnt == 53, "R10 busy restart no effect", wr_cnt, 53);
        push_bytes(20, 40, acc);
        wait_done(2, "R9 chain completes");
        chk(first_ptr == 0, "R6 head cleared after chain", first_ptr, 0);

        // R8 flush then refill to 64
        @(negedge clk); sw_flush = 1'b1;
        @(negedge clk); sw_flush = 1'b0;
        post_seq = seq;
        push_bytes(80, 90, acc);
        chk(acc == 64, "R8 refill after flush", acc, 64);
        chk(!in_ready, "R1 full at 64", in_ready, 0);
        put_desc(48, 5, 32'h4000, 0, 1);
        expect_desc(32'h4000, 5, post_seq);
        sw_first(32'hC0);
        sw_go();
        wait_done(3, "R8 drain after flush");
        repeat (3) @(negedge clk);
        chk(wr_cnt == 68, "R4 total writes", wr_cnt, 68);
        chk(exp_addr_q.size() == 0, "R4 scoreboard drained", exp_addr_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule